// File: doc/BRIEF.md
# Sampling Delay Window Search

This block takes a pass/fail map over a line of delay taps and picks the tap at which to sample. Bit i of the map is 1 when tap i passed. The block finds the longest run of consecutive passing taps. It then chooses a tap inside that run, biased toward the small-delay end. It also reports whether the run leaves enough margin.

A one-cycle `start_i` pulse captures the map. The block then walks the map as a sequential engine, one run position per clock. Each step jumps past the run just measured. When the walk ends, the block publishes the run start, run length, chosen phase and margin flag, and pulses `done_o` for one cycle. Those outputs hold until the next search ends. The block does not drive delay lines and does not issue tuning commands.

Top module: `dly_win_search`

## Requirements
- R1: After reset, `done_o`, `win_start_o`, `win_len_o`, `phase_o` and `margin_o` are all 0.
- R2: A `start_i` high at a clock edge while idle captures `map_i`. If the walk visits N positions, `done_o` is high in the cycle that follows the (N+1)-th rising edge after the capture edge.
- R3: The reported run is the longest run of consecutive 1 bits. A later run replaces the best run only if it is strictly longer, so among equal lengths the lowest-numbered run is reported.
- R4: Runs do not wrap from tap 31 to tap 0. A run starting at tap s counts at most 32 − s taps.
- R5: The walk begins at tap 0. After each position it advances by the run length measured there, or by 1 when that length is 0.
- R6: The walk ends early after a step in which the measured run length is at least 12 and the best run so far starts below tap 4.
- R7: The phase is start + length/3 when the best run starts at tap 0, and start + length/2 otherwise. Both use integer division and are taken modulo 32. The result is zero-extended to 8 bits.
- R8: An all-zero map reports phase 0xFF, start 0, length 0 and margin 0.
- R9: `margin_o` is 1 when the best length is at least 12, or when the best run starts at tap 0 and has length at least 4.
- R10: `start_i` has no effect while a search is in progress. `done_o` is high for exactly one cycle. The result outputs change only in the cycle in which `done_o` is high.
- R11: For any map, `done_o` follows the capture edge within 64 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures `map_i` when idle |
| map_i | input | 32 | Pass/fail map, bit i = tap i passed |
| done_o | output | 1 | One-cycle strobe: result valid |
| win_start_o | output | 5 | First tap of the best run |
| win_len_o | output | 6 | Length of the best run |
| phase_o | output | 8 | Chosen tap; 0xFF when no tap passed |
| margin_o | output | 1 | Best run has sufficient margin |

## Verification
The map patterns are chosen so that each one separates a specific behaviour:
- An all-zero map exercises the failure code.
- A full map exercises the one-third rule together with the earliest possible stop.
- Two equal runs show whether the earlier run wins the tie.
- A pair of runs touching tap 31 and tap 0 separates a wrapping count from a clipped one.
- A 12-tap run near tap 0 followed by a longer run shows whether the early stop hides the longer run. The same runs moved past tap 4 show that the walk continues.
- Short runs at tap 0 sit either side of the margin threshold.
- The alternating map forces the longest walk. It also carries a second start pulse in mid-search, which must be ignored.
- Random maps are compared cycle by cycle against a behavioural model for latency and results.

// File: rtl/dws_pkg.sv
package dws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } dws_state_e;
endpackage

// File: rtl/dws_run_len.sv
// Length of the run of ones beginning at pos_i, clipped at the top tap.
module dws_run_len #(
  parameter int TAPS  = 32,
  parameter int TAP_W = $clog2(TAPS),
  parameter int LEN_W = $clog2(TAPS + 1)
) (
  input  logic [TAPS-1:0]  map_i,
  input  logic [TAP_W-1:0] pos_i,
  output logic [LEN_W-1:0] len_o
);
  logic [TAPS-1:0] shifted;
  logic [TAPS-1:0] prefix;

  // zero fill from the shift stops the run at the top tap: no wrap
  assign shifted = map_i >> pos_i;

  for (genvar g = 0; g < TAPS; g++) begin : g_prefix
    if (g == 0) begin : g_first
      assign prefix[g] = shifted[g];
    end else begin : g_rest
      assign prefix[g] = prefix[g-1] & shifted[g];
    end
  end

  // prefix is a thermometer code; its population is the run length
  always_comb begin
    len_o = '0;
    for (int i = 0; i < TAPS; i++) len_o = len_o + LEN_W'(prefix[i]);
  end
endmodule

// File: rtl/dws_phase_pick.sv
// Chooses the sampling tap inside the best run and grades its margin.
module dws_phase_pick #(
  parameter int TAP_W    = 5,
  parameter int LEN_W    = 6,
  parameter int PH_W     = 8,
  parameter int GOOD_LEN = 12,
  parameter int ZERO_MIN = 4
) (
  input  logic [TAP_W-1:0] win_start_i,
  input  logic [LEN_W-1:0] win_len_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             margin_o
);
  localparam logic [LEN_W-1:0] GOOD_L = LEN_W'(GOOD_LEN);
  localparam logic [LEN_W-1:0] ZMIN_L = LEN_W'(ZERO_MIN);
  localparam logic [LEN_W-1:0] THREE  = LEN_W'(3);

  logic             at_zero;
  logic [LEN_W-1:0] offset;
  logic [TAP_W-1:0] tap_sum;

  assign at_zero = (win_start_i == '0);
  // runs anchored at tap 0 lean further toward the short-delay end
  assign offset  = at_zero ? (win_len_i / THREE) : (win_len_i >> 1);
  // truncation to TAP_W bits is the modulo over the tap count
  assign tap_sum = win_start_i + offset[TAP_W-1:0];

  always_comb begin
    if (win_len_i == '0) phase_o = '1;
    else                 phase_o = {{(PH_W-TAP_W){1'b0}}, tap_sum};
  end

  assign margin_o = (win_len_i >= GOOD_L) || (at_zero && (win_len_i >= ZMIN_L));
endmodule

// File: rtl/dly_win_search.sv
module dly_win_search #(
  parameter int TAPS     = 32,
  parameter int PH_W     = 8,
  parameter int GOOD_LEN = 12,
  parameter int NEAR_TAP = 4,
  parameter int ZERO_MIN = 4,
  localparam int TAP_W   = $clog2(TAPS),
  localparam int LEN_W   = $clog2(TAPS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAPS-1:0]  map_i,
  output logic             done_o,
  output logic [TAP_W-1:0] win_start_o,
  output logic [LEN_W-1:0] win_len_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             margin_o
);
  import dws_pkg::*;

  localparam int          POS_W   = LEN_W;
  localparam logic [POS_W-1:0] POS_END = POS_W'(TAPS);
  localparam logic [LEN_W-1:0] GOOD_L  = LEN_W'(GOOD_LEN);
  localparam logic [TAP_W-1:0] NEAR_L  = TAP_W'(NEAR_TAP);

  dws_state_e       state_q;
  logic [TAPS-1:0]  map_q;
  logic [POS_W-1:0] pos_q;
  logic [TAP_W-1:0] best_start_q;
  logic [LEN_W-1:0] best_len_q;

  logic [LEN_W-1:0] cur_len;
  logic             take_run;
  logic [TAP_W-1:0] nb_start;
  logic [LEN_W-1:0] nb_len;
  logic [POS_W-1:0] step;
  logic [POS_W-1:0] next_pos;
  logic             stop_scan;
  logic [PH_W-1:0]  pick_phase;
  logic             pick_margin;

  dws_run_len #(.TAPS(TAPS), .TAP_W(TAP_W), .LEN_W(LEN_W)) u_run_len (
    .map_i (map_q),
    .pos_i (pos_q[TAP_W-1:0]),
    .len_o (cur_len)
  );

  dws_phase_pick #(
    .TAP_W(TAP_W), .LEN_W(LEN_W), .PH_W(PH_W),
    .GOOD_LEN(GOOD_LEN), .ZERO_MIN(ZERO_MIN)
  ) u_phase_pick (
    .win_start_i (best_start_q),
    .win_len_i   (best_len_q),
    .phase_o     (pick_phase),
    .margin_o    (pick_margin)
  );

  always_comb begin
    // strict compare: the earliest of equal runs is kept
    take_run  = cur_len > best_len_q;
    nb_start  = take_run ? pos_q[TAP_W-1:0] : best_start_q;
    nb_len    = take_run ? cur_len : best_len_q;
    step      = (cur_len == '0) ? POS_W'(1) : cur_len;
    next_pos  = pos_q + step;
    stop_scan = (next_pos >= POS_END) || ((cur_len >= GOOD_L) && (nb_start < NEAR_L));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      map_q        <= '0;
      pos_q        <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
      done_o       <= 1'b0;
      win_start_o  <= '0;
      win_len_o    <= '0;
      phase_o      <= '0;
      margin_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            map_q        <= map_i;
            pos_q        <= '0;
            best_start_q <= '0;
            best_len_q   <= '0;
            state_q      <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          pos_q        <= next_pos;
          best_start_q <= nb_start;
          best_len_q   <= nb_len;
          if (stop_scan) state_q <= ST_FIN;
        end
        ST_FIN: begin
          win_start_o <= best_start_q;
          win_len_o   <= best_len_q;
          phase_o     <= pick_phase;
          margin_o    <= pick_margin;
          done_o      <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(phase_o) && $stable(win_start_o) && $stable(win_len_o) && $stable(margin_o)));

  // R10
  start_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(map_q));

  // R8
  fail_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (win_len_o == '0)) |-> ((phase_o == '1) && (win_start_o == '0) && !margin_o));

  // R4
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((int'(win_start_o) + int'(win_len_o)) <= TAPS));

  // R7
  phase_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (win_len_o != '0)) |->
      ((int'(phase_o) >= int'(win_start_o)) && (int'(phase_o) < int'(win_start_o) + int'(win_len_o))));

  // R11
  scan_progress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SCAN) && ($past(state_q) == ST_SCAN)) |-> (pos_q > $past(pos_q)));

  // R11
  pos_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN) |-> (pos_q < POS_END));
endmodule

// File: tb/dly_win_search_tb.sv
`timescale 1ns/1ps
module dly_win_search_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] map_i = '0;
  logic        done_o;
  logic [4:0]  win_start_o;
  logic [5:0]  win_len_o;
  logic [7:0]  phase_o;
  logic        margin_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  dly_win_search u_dut (
    .clk_i, .rst_ni, .start_i, .map_i, .done_o,
    .win_start_o, .win_len_o, .phase_o, .margin_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic ref_search(input logic [31:0] m, output int s, output int l,
                            output int ph, output int mg, output int steps);
    int pos = 0;
    int bs = 0;
    int bl = 0;
    steps = 0;
    while (pos < 32) begin
      int len = 0;
      while ((pos + len < 32) && m[pos+len]) len++;
      steps++;
      if (len > bl) begin bl = len; bs = pos; end
      pos += (len != 0) ? len : 1;
      if (len >= 12 && bs < 4) break;
    end
    if (bl == 0) begin s = 0; l = 0; ph = 255; end
    else begin
      s = bs; l = bl;
      ph = (bs == 0) ? (bs + bl / 3) % 32 : (bs + bl / 2) % 32;
    end
    mg = (bl >= 12 || (bs == 0 && bl >= 4)) ? 1 : 0;
  endtask

  // behavioural model: a busy flag and a countdown to the done cycle
  bit m_busy;
  int m_cnt;
  int r_s, r_l, r_ph, r_mg, r_steps;
  bit e_done;
  int e_s, e_l, e_ph, e_mg;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_cnt = 0; e_done = 0;
      e_s = 0; e_l = 0; e_ph = 0; e_mg = 0;
    end else begin
      cyc++;
      e_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; e_done = 1;
          e_s = r_s; e_l = r_l; e_ph = r_ph; e_mg = r_mg;
        end
      end else if (start_i) begin
        ref_search(map_i, r_s, r_l, r_ph, r_mg, r_steps);
        m_busy = 1;
        m_cnt = r_steps + 1;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      check(done_o == e_done, "R2 R5 done timing", done_o, e_done);
      if (e_done) begin
        check(int'(win_start_o) == e_s, "R3 start", win_start_o, e_s);
        check(int'(win_len_o) == e_l, "R3 length", win_len_o, e_l);
        check(int'(phase_o) == e_ph, "R7 phase", phase_o, e_ph);
        check(int'(margin_o) == e_mg, "R9 margin", margin_o, e_mg);
      end else begin
        check(int'(win_start_o) == e_s && int'(win_len_o) == e_l &&
              int'(phase_o) == e_ph && int'(margin_o) == e_mg,
              "R10 outputs hold", phase_o, e_ph);
      end
    end
  end

  // runs one search; optional second start pulse mid-search with another map
  task automatic run_case(input logic [31:0] m, input string tag,
                          input int xs, input int xl, input int xph, input int xmg,
                          input bit glitch);
    int lat = 0;
    @(negedge clk_i);
    start_i = 1'b1; map_i = m;
    @(negedge clk_i);
    start_i = 1'b0; map_i = ~m;
    lat = 1;
    while (!done_o && lat < 100) begin
      if (glitch && lat == 3) start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
    end
    check(lat <= 64, "R11 latency", lat, 64);
    check(int'(win_start_o) == xs, {tag, " start"}, win_start_o, xs);
    check(int'(win_len_o) == xl, {tag, " length"}, win_len_o, xl);
    check(int'(phase_o) == xph, {tag, " phase"}, phase_o, xph);
    check(int'(margin_o) == xmg, {tag, " margin"}, margin_o, xmg);
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(done_o == 0 && win_start_o == 0 && win_len_o == 0 && phase_o == 0 && margin_o == 0,
          "R1 reset outputs", phase_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(done_o == 0 && phase_o == 0, "R1 idle after reset", done_o, 0);

    run_case(32'h0000_0000, "R8 empty map", 0, 0, 255, 0, 0);
    run_case(32'hFFFF_FFFF, "R6 full map", 0, 32, 10, 1, 0);
    run_case(32'h0000_3CF0, "R3 tie", 4, 4, 6, 0, 0);
    run_case(32'hF000_0003, "R4 no wrap", 28, 4, 30, 0, 0);
    run_case(32'hFFFF_3FFC, "R6 early stop", 2, 12, 8, 1, 0);
    run_case(32'hFFFD_FFE0, "R6 no early stop", 18, 14, 25, 1, 0);
    run_case(32'h0000_001F, "R9 zero run margin", 0, 5, 1, 1, 0);
    run_case(32'h0000_0007, "R9 zero run short", 0, 3, 1, 0, 0);
    run_case(32'h8000_0000, "R7 top tap", 31, 1, 31, 0, 0);
    run_case(32'h00FF_F000, "R7 half rule", 12, 12, 18, 1, 0);
    run_case(32'h5555_5555, "R5 alternating", 0, 1, 0, 0, 0);
    run_case(32'hAAAA_AAAA, "R10 start ignored", 1, 1, 1, 0, 1);

    for (int k = 0; k < 40; k++) begin
      logic [31:0] rm;
      int s, l, ph, mg, st;
      rm = $urandom();
      if (k % 3 == 0) rm = rm | (rm >> 1) | (rm >> 2);
      ref_search(rm, s, l, ph, mg, st);
      run_case(rm, "R3 random", s, l, ph, mg, (k % 5 == 0));
    end
    repeat (3) @(negedge clk_i);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog expired: actual %0d expected %0d", cyc, 150000);
    summary();
  end
endmodule